// File: doc/BRIEF.md
# Spill-Aligned Calibration Pulse Burst Generator

This block issues a fixed-length train of calibration trigger pulses each time a spill begins. It watches a spill level input, registers it, and treats a low-to-high change of the registered level as the start of a spill. From that moment it waits a programmed number of clocks, then emits a one-clock trigger, followed by further triggers a programmed number of clocks apart, until the programmed number of pulses has been sent.

The three settings (delay to the first pulse, pulse spacing, pulse count) are sampled once, at the spill start, so software may rewrite them at any time without disturbing a train that is already running. If the spill ends early the rest of the train is dropped. A busy flag tells the surrounding trigger logic when a train is in progress.

Top module: `calib_trig_gen`

## Requirements
- R1: A train starts only on a 0-to-1 change of the registered spill level while `enable` is high and `cfg_count` is nonzero. Calling E0 the clock edge that first samples `spill` high, `busy` is high in the cycle after edge E0+1. With spill held high after a train has ended, no new train starts.
- R2: The first trigger is high for exactly the cycle following clock edge E0+2+`cfg_offset` (offset counted in clocks).
- R3: With `cfg_count` equal to 0, or `enable` low at the spill start, no trigger is issued and `busy` stays low.
- R4: Exactly `cfg_count` triggers are issued, trigger k (k from 0) following edge E0+2+`cfg_offset`+k·P, where P is `cfg_period` and a period of 0 is taken as 1.
- R5: If the registered spill level falls before the train completes (Ef being the edge that first samples `spill` low), no trigger is issued after edge Ef and `busy` is low from the cycle after edge Ef+1 on.
- R6: Offset, period and count are captured at the spill start; changing the configuration inputs during a train does not alter its timing or length.
- R7: Each trigger is a single-clock pulse, and `busy` stays high up to and including the cycle of the last trigger, then drops in the next cycle.
- R8: Reset is synchronous and active high; after reset `trig` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows a train to start at a spill start |
| spill | input | 1 | Spill level |
| cfg_offset | input | 32 | Clocks from spill start to first pulse |
| cfg_period | input | 32 | Clocks between pulses (0 acts as 1) |
| cfg_count | input | 16 | Pulses per spill (0 disables) |
| trig | output | 1 | One-clock calibration trigger |
| busy | output | 1 | High while a train is in progress |

## Verification
All timing is counted from E0, the edge that first samples spill high: busy is due one cycle later, the first pulse two cycles plus the offset later, and each later pulse one period after the previous; an abort takes effect one edge after spill is first sampled low. The bench keeps a free-running edge counter, records E0 and Ef when it drives spill, and at every falling clock edge of the train window compares trig and busy with values derived from those formulas, so every cycle, not only the pulse cycles, is checked, including the quiet cycles after a train.

// File: rtl/calib_pkg.sv
package calib_pkg;

    localparam int OFFSET_W = 32;
    localparam int PERIOD_W = 32;
    localparam int COUNT_W  = 16;
    localparam int TIMER_W  = (OFFSET_W > PERIOD_W) ? OFFSET_W : PERIOD_W;

    typedef struct packed {
        logic [OFFSET_W-1:0] offset;
        logic [PERIOD_W-1:0] period;
        logic [COUNT_W-1:0]  count;
    } calib_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_SPACE = 2'd2
    } seq_state_t;

    // reload value for the spacing timer: period of zero behaves as one
    function automatic logic [TIMER_W-1:0] space_reload(input logic [PERIOD_W-1:0] p);
        logic [TIMER_W-1:0] ext;
        ext = TIMER_W'(p);
        return (p == '0) ? '0 : ext - TIMER_W'(1);
    endfunction

endpackage

// File: rtl/calib_edge_det.sv
module calib_edge_det #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [DEPTH:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= din;
    end

    for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= 1'b0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign level = stage[DEPTH-1];
    assign rise  = stage[DEPTH-1] & ~stage[DEPTH];

    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/calib_cfg_latch.sv
module calib_cfg_latch
    import calib_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  calib_cfg_t cfg_in,
    output calib_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/calib_sequencer.sv
module calib_sequencer
    import calib_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       level,
    input  logic       enable,
    input  calib_cfg_t cfg_live,
    input  calib_cfg_t cfg_hold,
    output logic       start,
    output logic       active,
    output logic       trig
);
    seq_state_t           state;
    logic [TIMER_W-1:0]   timer;
    logic [COUNT_W-1:0]   remaining;

    assign start  = (state == SEQ_IDLE) && rise && enable && (cfg_live.count != '0);
    assign active = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            timer     <= '0;
            remaining <= '0;
            trig      <= 1'b0;
        end else begin
            trig <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        timer     <= TIMER_W'(cfg_live.offset);
                        remaining <= cfg_live.count;
                        state     <= SEQ_DELAY;
                    end
                end
                default: begin
                    if (!level) begin
                        state     <= SEQ_IDLE;
                        remaining <= '0;
                    end else if (timer == '0) begin
                        trig <= 1'b1;
                        if (remaining == COUNT_W'(1)) begin
                            remaining <= '0;
                            state     <= SEQ_IDLE;
                        end else begin
                            remaining <= remaining - COUNT_W'(1);
                            timer     <= space_reload(cfg_hold.period);
                            state     <= SEQ_SPACE;
                        end
                    end else begin
                        timer <= timer - TIMER_W'(1);
                    end
                end
            endcase
        end
    end

    p_start_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE && $past(state) == SEQ_IDLE) |-> $past(rise && enable));

    p_zero_count_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && cfg_live.count == '0) |=> state == SEQ_IDLE);

    p_remaining_live_r4: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE) |-> remaining != '0);

    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE && !level) |=> (state == SEQ_IDLE && !trig));

    p_trig_in_train_r7: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(state) != SEQ_IDLE);

endmodule

// File: rtl/calib_trig_gen.sv
module calib_trig_gen
    import calib_pkg::*;
#(
    parameter int SYNC_DEPTH = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                spill,
    input  logic [OFFSET_W-1:0] cfg_offset,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [COUNT_W-1:0]  cfg_count,
    output logic                trig,
    output logic                busy
);
    logic       spill_level;
    logic       spill_rise;
    logic       seq_start;
    logic       seq_active;
    calib_cfg_t cfg_live;
    calib_cfg_t cfg_hold;

    assign cfg_live = '{offset: cfg_offset, period: cfg_period, count: cfg_count};

    calib_edge_det #(.DEPTH(SYNC_DEPTH)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .din   (spill),
        .level (spill_level),
        .rise  (spill_rise)
    );

    calib_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (seq_start),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_hold)
    );

    calib_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .rise     (spill_rise),
        .level    (spill_level),
        .enable   (enable),
        .cfg_live (cfg_live),
        .cfg_hold (cfg_hold),
        .start    (seq_start),
        .active   (seq_active),
        .trig     (trig)
    );

    assign busy = seq_active | trig;

    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_active && $past(seq_active)) |-> $stable(cfg_hold));

    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(rst) |-> (!trig && !seq_active));

endmodule

// File: tb/tb_calib_trig_gen.sv
module tb_calib_trig_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        spill;
    logic [31:0] cfg_offset;
    logic [31:0] cfg_period;
    logic [15:0] cfg_count;
    logic        trig;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    calib_trig_gen dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .spill      (spill),
        .cfg_offset (cfg_offset),
        .cfg_period (cfg_period),
        .cfg_count  (cfg_count),
        .trig       (trig),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    function automatic bit exp_trig(longint n, longint e0, longint ef, longint off,
                                    longint p, longint cnt, bit en);
        longint d;
        if (!en || cnt == 0 || n > ef) return 1'b0;
        d = n - (e0 + 2 + off);
        if (d < 0 || (d % p) != 0) return 1'b0;
        return (d / p) < cnt;
    endfunction

    function automatic bit exp_busy(longint n, longint e0, longint ef, longint off,
                                    longint p, longint cnt, bit en);
        longint t_last;
        if (!en || cnt == 0) return 1'b0;
        t_last = e0 + 2 + off + (cnt - 1) * p;
        return (n >= e0 + 1) && (n <= ((t_last < ef) ? t_last : ef));
    endfunction

    // one spill: spill high for spill_len sampling edges starting at E0
    task automatic run_spill(input longint off, input longint per, input longint cnt,
                             input bit en, input longint spill_len, input bit perturb,
                             input string req);
        longint e0, ef, p, horizon, stop_at, n;
        bit te, be;
        @(negedge clk);
        cfg_offset = 32'(off);
        cfg_period = 32'(per);
        cfg_count  = 16'(cnt);
        enable     = en;
        spill      = 1'b1;
        e0 = cyc + 1;
        ef = e0 + spill_len;
        p  = (per == 0) ? 1 : per;
        horizon = (en && cnt > 0) ? e0 + 2 + off + (cnt - 1) * p + 6 : e0 + 8;
        stop_at = (ef + 4 < horizon) ? ef + 4 : horizon;
        while (1) begin
            @(negedge clk);
            n  = cyc;
            te = exp_trig(n, e0, ef, off, p, cnt, en);
            be = exp_busy(n, e0, ef, off, p, cnt, en);
            check(trig === te, req, "trig", longint'(trig), longint'(te));
            check(busy === be, req, "busy", longint'(busy), longint'(be));
            if (n >= stop_at) break;
            if (perturb && n == e0 + 2) begin
                cfg_offset = $urandom_range(0, 40);
                cfg_period = $urandom_range(0, 9);
                cfg_count  = 16'($urandom_range(0, 9));
                enable     = $urandom_range(0, 1);
            end
            if (n == ef - 1) spill = 1'b0;
        end
        spill = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; enable = 1'b0; spill = 1'b0;
        cfg_offset = '0; cfg_period = '0; cfg_count = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: outputs quiet after reset
        check(trig === 1'b0, "R8", "trig after reset", longint'(trig), 0);
        check(busy === 1'b0, "R8", "busy after reset", longint'(busy), 0);

        // R2: zero offset, R4 spacing
        run_spill(0, 3, 4, 1'b1, 1000, 1'b0, "R2 R4");
        // R2: long offset
        run_spill(100, 5, 2, 1'b1, 1000, 1'b0, "R2");
        // R4: period zero acts as one, back-to-back pulses
        run_spill(2, 0, 5, 1'b1, 1000, 1'b0, "R4");
        // R3: count zero
        run_spill(1, 2, 0, 1'b1, 30, 1'b0, "R3");
        // R3: enable low
        run_spill(1, 2, 3, 1'b0, 30, 1'b0, "R3");
        // R5: spill drops mid-train
        run_spill(3, 4, 6, 1'b1, 12, 1'b0, "R5");
        // R5: spill only one sampling edge high
        run_spill(0, 1, 3, 1'b1, 1, 1'b0, "R5");
        // R6: config rewritten during the train
        run_spill(4, 3, 4, 1'b1, 1000, 1'b1, "R6");
        // R7: single pulse train, busy ends after it; R1 no restart while high
        run_spill(5, 7, 1, 1'b1, 1000, 1'b0, "R1 R7");

        for (int i = 0; i < 40; i++) begin
            run_spill($urandom_range(0, 15), $urandom_range(0, 6), $urandom_range(0, 5),
                      ($urandom_range(0, 9) != 0),
                      ($urandom_range(0, 2) == 0) ? longint'($urandom_range(1, 40)) : 1000,
                      $urandom_range(0, 1), "R1 R2 R4 R5 R6 R7");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule